// File: doc/BRIEF.md
# Sparse Deconvolution Coordinate Generator

This block places the products of a sparse transposed-convolution engine in the output feature map. The engine shares one non-zero weight across a tile of processing elements laid out as rows, columns and planes. Each weight beat carries the kernel position of that weight along height, width and depth, because zero weights are dropped before they reach the engine. For every element of the tile, the block returns the output coordinate where that element's product lands.

A tile is opened with a start pulse. The pulse samples the operating mode (2D or 3D), the kernel size K, the stride S and the activation index of the tile's corner element. After that, weight beats arrive over a valid/ready handshake. Only the corner element's coordinate is formed with a multiply-add, giving activation index times S plus kernel index. Each neighbouring element adds S to the coordinate of the element before it along the same axis. With every beat the block also reports, per axis, whether the products fall in the part of a result block that overlaps the block of the next activation along that axis. The engine uses these flags to route partial sums between neighbours.

In 2D mode each plane of the tile works on its own feature map. Depth plays no part there.

Top module: `sdc_coord_gen`

## Requirements
- R1: After reset, out_valid is 0 and w_ready is 1.
- R2: For the tile element at row 0, column 0, plane 0, each output coordinate equals (corner index × S + kernel index) modulo 4096. This holds for height, width and, in 3D mode, depth.
- R3: The element at row r, column c, plane z sits in slot p = (z·ROWS + r)·COLS + c of each flat coordinate output, at bits [p·12 +: 12]. Its height coordinate is the corner height coordinate plus r·S, and its width coordinate is the corner width coordinate plus c·S. In 3D mode its depth coordinate is the corner depth coordinate plus z·S. All sums are taken modulo 4096.
- R4: out_ovl bit 0 (height), bit 1 (width) and bit 2 (depth) are each 1 exactly when the beat's kernel index on that axis is at least S.
- R5: In 2D mode every depth coordinate is 0 and out_ovl bit 2 is 0, whatever w_kd and base_d carry.
- R6: A beat is accepted on a clock edge where w_valid and w_ready are both 1, and its results appear with out_valid in the next cycle. While out_valid is 1 and out_ready is 0, w_ready is 0 and the outputs hold.
- R7: Mode, K, S and the corner indices are taken only on a start pulse. Changing these inputs at any other time has no effect on later beats.
- R8: On a start cycle w_ready is 0, so no beat is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Opens a tile and samples the configuration |
| cfg_3d | input | 1 | 1 selects 3D mode, 0 selects 2D mode |
| cfg_stride | input | 2 | Stride S, 1 or 2 |
| cfg_ksize | input | 3 | Kernel size K, 1 to 5 |
| base_h | input | 12 | Corner activation height index |
| base_w | input | 12 | Corner activation width index |
| base_d | input | 12 | Corner activation depth index |
| w_valid | input | 1 | Weight beat valid |
| w_ready | output | 1 | Weight beat can be accepted |
| w_kh | input | 3 | Kernel height index of the weight |
| w_kw | input | 3 | Kernel width index of the weight |
| w_kd | input | 3 | Kernel depth index of the weight |
| out_valid | output | 1 | Coordinate set valid |
| out_ready | input | 1 | Consumer takes the coordinate set |
| out_h | output | 12·ROWS·COLS·PLANES | Height coordinate per tile element |
| out_w | output | 12·ROWS·COLS·PLANES | Width coordinate per tile element |
| out_d | output | 12·ROWS·COLS·PLANES | Depth coordinate per tile element |
| out_ovl | output | 3 | Overlap flags: height, width, depth |

## Verification
The overlap assertions rely on three input conditions: every kernel index is below K, S is 1 or 2, and a start pulse arrives only while no coordinate set is waiting for the consumer. Under those conditions, an index of at least S always lies inside the overlap band of length K − S. The stimulus enforces the conditions itself. Random kernel indices are drawn modulo the K sampled for the tile, S is drawn from the two legal values, and a start is issued only after out_valid has dropped. Directed cases cover address wrap at 4095, a stalled consumer, configuration inputs that change without a start, and a 2D beat that carries a nonzero depth index.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int CRD_W = 12;
  localparam int IDX_W = 3;
  localparam int STR_W = 2;
  localparam int KSZ_W = 3;

  typedef logic [CRD_W-1:0] crd_t;
  typedef logic [IDX_W-1:0] idx_t;

  typedef struct packed {
    crd_t h;
    crd_t w;
    crd_t d;
  } crd3_t;

  typedef enum int {AX_H = 0, AX_W = 1, AX_D = 2} axis_e;

  // corner index times stride plus kernel index, modulo 2^CRD_W
  function automatic crd_t mul_add(crd_t b, logic [STR_W-1:0] s, idx_t k);
    logic [CRD_W+STR_W-1:0] prod;
    prod = {{STR_W{1'b0}}, b} * {{CRD_W{1'b0}}, s};
    return prod[CRD_W-1:0] + {{(CRD_W-IDX_W){1'b0}}, k};
  endfunction
endpackage

// File: rtl/sdc_cfg_regs.sv
module sdc_cfg_regs
  import sdc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cfg_3d,
  input  logic [STR_W-1:0] cfg_stride,
  input  logic [KSZ_W-1:0] cfg_ksize,
  input  crd3_t            base_in,
  output logic             mode3d_q,
  output logic [STR_W-1:0] stride_q,
  output logic [KSZ_W-1:0] ksize_q,
  output crd3_t            base_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode3d_q <= 1'b0;
      stride_q <= STR_W'(1);
      ksize_q  <= KSZ_W'(1);
      base_q   <= '0;
    end else if (start) begin
      mode3d_q <= cfg_3d;
      stride_q <= cfg_stride;
      ksize_q  <= cfg_ksize;
      base_q   <= base_in;
    end
  end
endmodule

// File: rtl/sdc_anchor.sv
module sdc_anchor
  import sdc_pkg::*;
(
  input  crd3_t            base,
  input  logic [STR_W-1:0] stride,
  input  logic             mode3d,
  input  idx_t             kh,
  input  idx_t             kw,
  input  idx_t             kd,
  output crd3_t            anchor
);
  always_comb begin
    anchor.h = mul_add(base.h, stride, kh);
    anchor.w = mul_add(base.w, stride, kw);
    anchor.d = mode3d ? mul_add(base.d, stride, kd) : '0;
  end
endmodule

// File: rtl/sdc_fanout.sv
module sdc_fanout
  import sdc_pkg::*;
#(
  parameter int ROWS   = 4,
  parameter int COLS   = 4,
  parameter int PLANES = 2,
  localparam int NPE   = ROWS * COLS * PLANES
) (
  input  crd3_t                anchor,
  input  logic [STR_W-1:0]     stride,
  input  logic                 mode3d,
  output logic [NPE*CRD_W-1:0] h_all,
  output logic [NPE*CRD_W-1:0] w_all,
  output logic [NPE*CRD_W-1:0] d_all
);
  crd_t step;
  crd_t row_c [ROWS];
  crd_t col_c [COLS];
  crd_t pl_c  [PLANES];

  assign step     = {{(CRD_W-STR_W){1'b0}}, stride};
  assign row_c[0] = anchor.h;
  assign col_c[0] = anchor.w;
  assign pl_c[0]  = anchor.d;

  for (genvar gr = 1; gr < ROWS; gr++) begin : g_row
    assign row_c[gr] = row_c[gr-1] + step;
  end
  for (genvar gc = 1; gc < COLS; gc++) begin : g_col
    assign col_c[gc] = col_c[gc-1] + step;
  end
  for (genvar gz = 1; gz < PLANES; gz++) begin : g_pl
    assign pl_c[gz] = mode3d ? (pl_c[gz-1] + step) : '0;
  end

  for (genvar z = 0; z < PLANES; z++) begin : g_z
    for (genvar r = 0; r < ROWS; r++) begin : g_r
      for (genvar c = 0; c < COLS; c++) begin : g_c
        localparam int P = (z * ROWS + r) * COLS + c;
        assign h_all[P*CRD_W +: CRD_W] = row_c[r];
        assign w_all[P*CRD_W +: CRD_W] = col_c[c];
        assign d_all[P*CRD_W +: CRD_W] = pl_c[z];
      end
    end
  end
endmodule

// File: rtl/sdc_ovl_class.sv
module sdc_ovl_class
  import sdc_pkg::*;
(
  input  idx_t             kh,
  input  idx_t             kw,
  input  idx_t             kd,
  input  logic [STR_W-1:0] stride,
  input  logic [KSZ_W-1:0] ksize,
  input  logic             mode3d,
  output logic [2:0]       ovl
);
  logic [IDX_W-1:0] s_ext;
  logic [KSZ_W-1:0] s_k;
  logic             band;

  assign s_ext = {{(IDX_W-STR_W){1'b0}}, stride};
  assign s_k   = {{(KSZ_W-STR_W){1'b0}}, stride};
  assign band  = s_k < ksize;

  always_comb begin
    ovl        = '0;
    ovl[AX_H]  = band && (kh >= s_ext);
    ovl[AX_W]  = band && (kw >= s_ext);
    ovl[AX_D]  = band && mode3d && (kd >= s_ext);
  end
endmodule

// File: rtl/sdc_coord_gen.sv
module sdc_coord_gen
  import sdc_pkg::*;
#(
  parameter int ROWS   = 4,
  parameter int COLS   = 4,
  parameter int PLANES = 2,
  localparam int NPE   = ROWS * COLS * PLANES
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 cfg_3d,
  input  logic [STR_W-1:0]     cfg_stride,
  input  logic [KSZ_W-1:0]     cfg_ksize,
  input  logic [CRD_W-1:0]     base_h,
  input  logic [CRD_W-1:0]     base_w,
  input  logic [CRD_W-1:0]     base_d,
  input  logic                 w_valid,
  output logic                 w_ready,
  input  logic [IDX_W-1:0]     w_kh,
  input  logic [IDX_W-1:0]     w_kw,
  input  logic [IDX_W-1:0]     w_kd,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [NPE*CRD_W-1:0] out_h,
  output logic [NPE*CRD_W-1:0] out_w,
  output logic [NPE*CRD_W-1:0] out_d,
  output logic [2:0]           out_ovl
);
  logic             mode3d_q;
  logic [STR_W-1:0] stride_q;
  logic [KSZ_W-1:0] ksize_q;
  crd3_t            base_q;
  crd3_t            base_in;
  crd3_t            anchor;
  logic [NPE*CRD_W-1:0] h_n, w_n, d_n;
  logic [2:0]       ovl_n;
  logic             fire;

  assign base_in = '{h: base_h, w: base_w, d: base_d};

  sdc_cfg_regs u_cfg (
    .clk(clk), .rst(rst), .start(start), .cfg_3d(cfg_3d),
    .cfg_stride(cfg_stride), .cfg_ksize(cfg_ksize), .base_in(base_in),
    .mode3d_q(mode3d_q), .stride_q(stride_q), .ksize_q(ksize_q),
    .base_q(base_q)
  );

  sdc_anchor u_anchor (
    .base(base_q), .stride(stride_q), .mode3d(mode3d_q),
    .kh(w_kh), .kw(w_kw), .kd(w_kd), .anchor(anchor)
  );

  sdc_fanout #(.ROWS(ROWS), .COLS(COLS), .PLANES(PLANES)) u_fan (
    .anchor(anchor), .stride(stride_q), .mode3d(mode3d_q),
    .h_all(h_n), .w_all(w_n), .d_all(d_n)
  );

  sdc_ovl_class u_ovl (
    .kh(w_kh), .kw(w_kw), .kd(w_kd), .stride(stride_q),
    .ksize(ksize_q), .mode3d(mode3d_q), .ovl(ovl_n)
  );

  assign w_ready = !start && (!out_valid || out_ready);
  assign fire    = w_valid && w_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_h     <= '0;
      out_w     <= '0;
      out_d     <= '0;
      out_ovl   <= '0;
    end else if (fire) begin
      out_valid <= 1'b1;
      out_h     <= h_n;
      out_w     <= w_n;
      out_d     <= d_n;
      out_ovl   <= ovl_n;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sdc_coord_gen_chk.sv
module sdc_coord_gen_chk
  import sdc_pkg::*;
#(
  parameter int ROWS   = 4,
  parameter int COLS   = 4,
  parameter int PLANES = 2,
  localparam int NPE   = ROWS * COLS * PLANES
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 start,
  input logic                 w_valid,
  input logic                 w_ready,
  input logic [IDX_W-1:0]     w_kh,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [NPE*CRD_W-1:0] out_h,
  input logic [NPE*CRD_W-1:0] out_d,
  input logic [2:0]           out_ovl,
  input logic                 mode3d_q,
  input logic [STR_W-1:0]     stride_q
);
  // R6
  hold_out_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_h) && $stable(out_ovl));

  // R6
  stall_ready_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !w_ready);

  // R6
  accept_latency_chk: assert property (@(posedge clk) disable iff (rst)
    w_valid && w_ready |=> out_valid);

  // R8
  start_block_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> !w_ready);

  // R5
  flat_depth_chk: assert property (@(posedge clk) disable iff (rst)
    w_valid && w_ready && !mode3d_q |=> (out_d == '0) && !out_ovl[2]);

  // R4
  ovl_height_chk: assert property (@(posedge clk) disable iff (rst)
    w_valid && w_ready |=>
      out_ovl[0] == ($past(w_kh) >= {{(IDX_W-STR_W){1'b0}}, $past(stride_q)}));

  if (ROWS > 1) begin : g_step
    // R3
    row_step_chk: assert property (@(posedge clk) disable iff (rst)
      w_valid && w_ready |=>
        (out_h[COLS*CRD_W +: CRD_W] - out_h[0 +: CRD_W]) ==
          {{(CRD_W-STR_W){1'b0}}, $past(stride_q)});
  end
endmodule

bind sdc_coord_gen sdc_coord_gen_chk #(.ROWS(ROWS), .COLS(COLS), .PLANES(PLANES)) chk_i (
  .clk(clk), .rst(rst), .start(start), .w_valid(w_valid), .w_ready(w_ready),
  .w_kh(w_kh), .out_valid(out_valid), .out_ready(out_ready), .out_h(out_h),
  .out_d(out_d), .out_ovl(out_ovl), .mode3d_q(mode3d_q), .stride_q(stride_q)
);

// File: tb/sdc_coord_gen_tb.sv
module sdc_coord_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 4, COLS = 4, PLANES = 2;
  localparam int NPE  = ROWS * COLS * PLANES;
  localparam int CW   = 12;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, cfg_3d = 1'b0;
  logic [1:0] cfg_stride = 2'd1;
  logic [2:0] cfg_ksize = 3'd3;
  logic [CW-1:0] base_h = '0, base_w = '0, base_d = '0;
  logic w_valid = 1'b0, w_ready, out_valid, out_ready = 1'b1;
  logic [2:0] w_kh = '0, w_kw = '0, w_kd = '0, out_ovl;
  logic [NPE*CW-1:0] out_h, out_w, out_d;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // bench copy of the configuration taken at start
  bit m3;
  int ms, mk, mbh, mbw, mbd;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdc_coord_gen #(.ROWS(ROWS), .COLS(COLS), .PLANES(PLANES)) dut_i (
    .clk(clk), .rst(rst), .start(start), .cfg_3d(cfg_3d),
    .cfg_stride(cfg_stride), .cfg_ksize(cfg_ksize), .base_h(base_h),
    .base_w(base_w), .base_d(base_d), .w_valid(w_valid), .w_ready(w_ready),
    .w_kh(w_kh), .w_kw(w_kw), .w_kd(w_kd), .out_valid(out_valid),
    .out_ready(out_ready), .out_h(out_h), .out_w(out_w), .out_d(out_d),
    .out_ovl(out_ovl)
  );

  function automatic int place(int base, int s, int k, int off);
    return ((base + off) * s + k) % 4096;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic open_tile(bit d3, int k, int s, int bh, int bw, int bd);
    @(negedge clk);
    start = 1'b1; cfg_3d = d3; cfg_ksize = 3'(k); cfg_stride = 2'(s);
    base_h = CW'(bh); base_w = CW'(bw); base_d = CW'(bd);
    m3 = d3; mk = k; ms = s; mbh = bh; mbw = bw; mbd = bd;
    #1;
    check(w_ready == 1'b0, "R8 ready during start", int'(w_ready), 0);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic compare_all(int kh, int kw, int kd, string req);
    int bad_h = 0, bad_w = 0, bad_d = 0;
    int eh = 0, ah = 0;
    int exp_ovl;
    for (int z = 0; z < PLANES; z++)
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++) begin
          int p = (z * ROWS + r) * COLS + c;
          int xh = place(mbh, ms, kh, r);
          int xw = place(mbw, ms, kw, c);
          int xd = m3 ? place(mbd, ms, kd, z) : 0;
          if (int'(out_h[p*CW +: CW]) != xh) begin bad_h++; eh = xh; ah = int'(out_h[p*CW +: CW]); end
          if (int'(out_w[p*CW +: CW]) != xw) bad_w++;
          if (int'(out_d[p*CW +: CW]) != xd) bad_d++;
        end
    exp_ovl = ((m3 && kd >= ms) ? 4 : 0) + ((kw >= ms) ? 2 : 0) + ((kh >= ms) ? 1 : 0);
    check(out_valid == 1'b1, {req, " valid"}, int'(out_valid), 1);
    check(bad_h == 0, {req, " R2 R3 height coords"}, ah, eh);
    check(bad_w == 0, {req, " R2 R3 width coords mismatches"}, bad_w, 0);
    check(bad_d == 0, {req, " R2 R3 R5 depth coords mismatches"}, bad_d, 0);
    check(int'(out_ovl) == exp_ovl, {req, " R4 overlap flags"}, int'(out_ovl), exp_ovl);
  endtask

  task automatic send(int kh, int kw, int kd, string req);
    @(negedge clk);
    w_valid = 1'b1; w_kh = 3'(kh); w_kw = 3'(kw); w_kd = 3'(kd);
    @(negedge clk);
    w_valid = 1'b0;
    compare_all(kh, kw, kd, req);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    check(w_ready == 1'b1, "R1 w_ready after reset", int'(w_ready), 1);

    // 3D, S=2, K=3
    open_tile(1'b1, 3, 2, 1, 2, 3);
    send(0, 0, 0, "R2 corner zero weight");
    send(2, 1, 2, "R4 mixed overlap");
    // 2D ignores depth index and base depth
    open_tile(1'b0, 3, 2, 5, 7, 9);
    send(1, 2, 2, "R5 flat mode");
    // stride 1
    open_tile(1'b1, 4, 1, 10, 20, 30);
    send(3, 0, 1, "R3 stride one");
    // wrap at 4095
    open_tile(1'b1, 3, 2, 4095, 4094, 4095);
    send(1, 2, 0, "R2 wrap");
    // K equal to S: no overlap band
    open_tile(1'b1, 2, 2, 3, 3, 3);
    send(1, 1, 1, "R4 no band");

    // R7: config inputs move without start
    open_tile(1'b1, 3, 2, 4, 4, 4);
    @(negedge clk);
    cfg_3d = 1'b0; cfg_stride = 2'd1; cfg_ksize = 3'd5;
    base_h = 12'd100; base_w = 12'd200; base_d = 12'd300;
    send(2, 2, 2, "R7 config held");

    // R6: stalled consumer
    @(negedge clk);
    out_ready = 1'b0;
    w_valid = 1'b1; w_kh = 3'd1; w_kw = 3'd0; w_kd = 3'd2;
    @(negedge clk);
    check(w_ready == 1'b0, "R6 ready low while stalled", int'(w_ready), 1'b0);
    w_kh = 3'd2; w_kw = 3'd2; w_kd = 3'd0;
    repeat (2) @(negedge clk);
    compare_all(1, 0, 2, "R6 held under stall");
    out_ready = 1'b1;
    @(negedge clk);
    w_valid = 1'b0;
    compare_all(2, 2, 0, "R6 next beat after release");
    @(negedge clk);
    check(out_valid == 1'b0, "R6 valid drops when drained", int'(out_valid), 0);

    // constrained random tiles
    for (int t = 0; t < 40; t++) begin
      bit d3 = 1'($urandom_range(0, 1));
      int k  = int'($urandom_range(1, 5));
      int s  = int'($urandom_range(1, 2));
      open_tile(d3, k, s, int'($urandom_range(0, 4095)),
                int'($urandom_range(0, 4095)), int'($urandom_range(0, 4095)));
      for (int b = 0; b < 6; b++)
        send(int'($urandom_range(0, k-1)), int'($urandom_range(0, k-1)),
             int'($urandom_range(0, k-1)), "R2 R3 R4 random");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule